// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers interrupt events for a small embedded CPU core: two external pins, overflow pulses from three timers, one external-transition pulse from the third timer, receive and transmit completion from a serial port, and four event pulses from an I2C engine. Each event sets its own flag bit. Software can set or clear any flag bit directly, and the effect is the same as a hardware set or clear. A bank of enable bits holds one enable per vector, one enable per I2C event and one global enable. All enable bits are 0 after reset.

Seven vectors compete in a fixed priority order. The winning vector index is shown on `irq_vec` with `irq_req` high and stays frozen until the core acknowledges it. The acknowledge moves the controller into service, and further requests are held back until the return strobe. Some flags clear themselves on acknowledge and others stay set until software clears them. External pins are synchronised and then sampled once every `SAMPLE_DIV` clocks. Each pin works in edge mode or level mode, selected by its mode bit.

The control state machine has three named states. `S_IDLE` has no request outstanding. `S_REQ` drives a request with a latched vector. `S_SERV` marks an acknowledged interrupt in service. The transitions are: `S_IDLE -> S_REQ` when any enabled source is pending and the global enable is on; `S_REQ -> S_SERV` on `irq_ack`; `S_SERV -> S_IDLE` on `irq_reti`. All other conditions hold the current state.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all flags and all enables are 0 and `irq_req` is low.
- R2: With `ext_mode[i]`=1, a high-to-low change on `ext_pin[i]` sets that pin's flag within 2*SAMPLE_DIV+4 clocks. A pin held steadily low does not set it again after software clears it. Flag bit 0 belongs to pin 0 and bit 2 to pin 1.
- R3: With `ext_mode[i]`=0, a low on the pin lasting at least SAMPLE_DIV clocks sets the flag within 2*SAMPLE_DIV+4 clocks. The flag stays set after the pin returns high.
- R4: Flag bit k is set on the clock after `flag_set[k]` or its hardware event, and cleared on the clock after `flag_clr[k]`. Set wins if both happen together. Flag layout: 0 pin0, 1 timer0, 2 pin1, 3 timer1, 4 serial rx, 5 serial tx, 6 timer2 overflow, 7 timer2 transition, 8..11 I2C events 0..3. The hardware pulses `tmr0_ovf`, `tmr1_ovf`, `ser_rx_done`, `ser_tx_done`, `tmr2_ovf`, `tmr2_ext` map to flag bits 1, 3, 4, 5, 6, 7.
- R5: Enable bits are written with `en_set`/`en_clr` using the same set-wins rule. Layout: 0..6 per vector, 7..10 per I2C event, 11 global. A pending flag whose vector enable is 0, or any flag while the global enable is 0, raises no request.
- R6: A request appears one clock after its enabled flag is set. Among pending vectors the lowest index wins. The order is 0 pin0, 1 timer0, 2 pin1, 3 timer1, 4 serial, 5 timer2, 6 I2C.
- R7: While `irq_req` is high and no acknowledge has come, `irq_req` and `irq_vec` stay unchanged, even when a higher-priority source becomes pending.
- R8: On acknowledge, the flag of the winning vector clears on the same clock if that vector is timer0 or timer1, or is an external pin in edge mode.
- R9: On acknowledge, a pin flag in level mode, the serial flags, the timer2 flags and the I2C flags are left unchanged.
- R10: After an acknowledge, `irq_req` stays low until `irq_reti`. If an enabled source is still pending, the next request follows one clock after the controller returns to `S_IDLE`.
- R11: Vector 4 is pending on serial rx OR tx, and vector 5 on timer2 overflow OR transition. Vector 6 is pending only when a set I2C flag also has its own I2C event enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 2 | External interrupt pins, asynchronous |
| ext_mode | input | 2 | Per-pin mode: 1 edge, 0 level |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tmr2_ext | input | 1 | Timer 2 external transition pulse |
| ser_rx_done | input | 1 | Serial byte received pulse |
| ser_tx_done | input | 1 | Serial byte sent pulse |
| i2c_evt | input | 4 | I2C event pulses: rx, tx, failure, no-ack |
| flag_set | input | 12 | Software flag set strobes |
| flag_clr | input | 12 | Software flag clear strobes |
| en_set | input | 12 | Enable set strobes |
| en_clr | input | 12 | Enable clear strobes |
| irq_ack | input | 1 | Core acknowledge of the request |
| irq_reti | input | 1 | Return-from-interrupt strobe |
| flags | output | 12 | Current flag bits |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 3 | Index of the requested vector |

## Verification
A flag write or hardware pulse shows in `flags` one clock after its strobe. The request follows one clock later. An acknowledge drops `irq_req` and applies the automatic clears in the same clock. After `irq_reti` the request needs two clocks to return: one to reach `S_IDLE` and one to reach `S_REQ`. Pin events reach the flag after two synchroniser stages plus up to one sample period. Since the bench does not track the sample phase, it waits 2*SAMPLE_DIV+4 clocks after every pin change. The bench drives inputs on falling clock edges and samples each result on the falling edge after the rising edge that makes it due. For all 49 ordered pairs of vectors it computes the expected winner and the expected remaining flags arithmetically.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NVEC  = 7;
    localparam int VW    = $clog2(NVEC);
    localparam int NI2C  = 4;
    localparam int NFLAG = 8 + NI2C;
    localparam int NEN   = NVEC + NI2C + 1;

    // flag bit positions
    localparam int F_X0  = 0;
    localparam int F_T0  = 1;
    localparam int F_X1  = 2;
    localparam int F_T1  = 3;
    localparam int F_SRX = 4;
    localparam int F_STX = 5;
    localparam int F_T2O = 6;
    localparam int F_T2X = 7;
    localparam int F_I2C = 8;

    // enable bit positions
    localparam int E_I2C = NVEC;
    localparam int E_GLB = NVEC + NI2C;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_SERV = 2'd2
    } irq_state_e;
endpackage

// File: rtl/irq_tick.sv
module irq_tick #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(DIV - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_mode,
    input  logic tick,
    output logic evt
);
    logic [1:0] sync_q;
    logic       samp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            samp_q <= 1'b1;
            evt    <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin};
            if (tick) begin
                samp_q <= sync_q[1];
                // edge: high sample then low sample; level: any low sample
                evt    <= edge_mode ? (samp_q & ~sync_q[1]) : ~sync_q[1];
            end else begin
                evt    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_bit_bank.sv
module irq_bit_bank #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= (q & ~clr_i) | set_i;
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic [N-1:0] pend,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = W'(i);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int SAMPLE_DIV = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ext_pin,
    input  logic [1:0]       ext_mode,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             tmr2_ovf,
    input  logic             tmr2_ext,
    input  logic             ser_rx_done,
    input  logic             ser_tx_done,
    input  logic [NI2C-1:0]  i2c_evt,
    input  logic [NFLAG-1:0] flag_set,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic [NEN-1:0]   en_set,
    input  logic [NEN-1:0]   en_clr,
    input  logic             irq_ack,
    input  logic             irq_reti,
    output logic [NFLAG-1:0] flags,
    output logic             irq_req,
    output logic [VW-1:0]    irq_vec
);
    localparam int NPIN = 2;
    localparam int PIN_FLAG [NPIN] = '{F_X0, F_X1};

    logic             tick;
    logic [NPIN-1:0]  ext_evt;
    logic [NFLAG-1:0] hw_evt;
    logic [NFLAG-1:0] auto_clr;
    logic [NEN-1:0]   en_q;
    logic [NVEC-1:0]  pend;
    logic             any_pend;
    logic [VW-1:0]    win;
    logic [VW-1:0]    vec_q;
    logic             take;
    irq_state_e       state, nxt;

    irq_tick #(.DIV(SAMPLE_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        irq_ext_sense u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (ext_pin[p]),
            .edge_mode (ext_mode[p]),
            .tick      (tick),
            .evt       (ext_evt[p])
        );
    end

    always_comb begin
        hw_evt = '0;
        for (int p = 0; p < NPIN; p++) hw_evt[PIN_FLAG[p]] = ext_evt[p];
        hw_evt[F_T0]  = tmr0_ovf;
        hw_evt[F_T1]  = tmr1_ovf;
        hw_evt[F_SRX] = ser_rx_done;
        hw_evt[F_STX] = ser_tx_done;
        hw_evt[F_T2O] = tmr2_ovf;
        hw_evt[F_T2X] = tmr2_ext;
        hw_evt[F_I2C +: NI2C] = i2c_evt;
    end

    irq_bit_bank #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set | hw_evt),
        .clr_i (flag_clr | auto_clr),
        .q     (flags)
    );

    irq_bit_bank #(.N(NEN)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set),
        .clr_i (en_clr),
        .q     (en_q)
    );

    // per-vector pending, all gated by the global enable
    always_comb begin
        pend[0] = flags[F_X0];
        pend[1] = flags[F_T0];
        pend[2] = flags[F_X1];
        pend[3] = flags[F_T1];
        pend[4] = flags[F_SRX] | flags[F_STX];
        pend[5] = flags[F_T2O] | flags[F_T2X];
        pend[6] = |(flags[F_I2C +: NI2C] & en_q[E_I2C +: NI2C]);
        pend    = pend & en_q[NVEC-1:0] & {NVEC{en_q[E_GLB]}};
    end

    irq_prio_enc #(.N(NVEC), .W(VW)) u_enc (
        .pend (pend),
        .any  (any_pend),
        .idx  (win)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            vec_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && any_pend) vec_q <= win;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (any_pend) nxt = S_REQ;
            S_REQ:   if (irq_ack)  nxt = S_SERV;
            S_SERV:  if (irq_reti) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs and acknowledge side effects
    always_comb begin
        irq_req  = (state == S_REQ);
        irq_vec  = vec_q;
        take     = (state == S_REQ) && irq_ack;
        auto_clr = '0;
        if (take) begin
            case (vec_q)
                VW'(0):  auto_clr[F_X0] = ext_mode[0];
                VW'(1):  auto_clr[F_T0] = 1'b1;
                VW'(2):  auto_clr[F_X1] = ext_mode[1];
                VW'(3):  auto_clr[F_T1] = 1'b1;
                default: auto_clr = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic             irq_ack,
    input logic [VW-1:0]    irq_vec,
    input logic [NFLAG-1:0] flags,
    input logic [NFLAG-1:0] flag_set,
    input logic [NFLAG-1:0] flag_clr,
    input logic [NFLAG-1:0] hw_evt,
    input logic [NEN-1:0]   en_q
);
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set)));

    p_sw_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr & ~flag_set & ~hw_evt) != '0)
        |=> ((flags & $past(flag_clr & ~flag_set & ~hw_evt)) == '0));

    p_global_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !en_q[E_GLB]) |=> !irq_req);

    p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec < VW'(NVEC)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    p_autoclr_t0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && irq_vec == VW'(1) && !flag_set[F_T0] && !hw_evt[F_T0])
        |=> !flags[F_T0]);

    p_keep_serial_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && irq_vec == VW'(4) && flags[F_SRX] && !flag_clr[F_SRX])
        |=> flags[F_SRX]);

    p_in_service_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .irq_vec  (irq_vec),
    .flags    (flags),
    .flag_set (flag_set),
    .flag_clr (flag_clr),
    .hw_evt   (hw_evt),
    .en_q     (en_q)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 12;
    localparam int PIN_WAIT   = 2 * DIV + 4;
    localparam int WD_CYCLES  = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin = 2'b11;
    logic [1:0]  ext_mode = 2'b11;
    logic        tmr0_ovf = 0, tmr1_ovf = 0, tmr2_ovf = 0, tmr2_ext = 0;
    logic        ser_rx_done = 0, ser_tx_done = 0;
    logic [3:0]  i2c_evt = '0;
    logic [11:0] flag_set = '0, flag_clr = '0, en_set = '0, en_clr = '0;
    logic        irq_ack = 0, irq_reti = 0;
    logic [11:0] flags;
    logic        irq_req;
    logic [2:0]  irq_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_ctrl #(.SAMPLE_DIV(DIV)) u_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_mode(ext_mode),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr2_ovf(tmr2_ovf),
        .tmr2_ext(tmr2_ext), .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
        .i2c_evt(i2c_evt), .flag_set(flag_set), .flag_clr(flag_clr),
        .en_set(en_set), .en_clr(en_clr), .irq_ack(irq_ack), .irq_reti(irq_reti),
        .flags(flags), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fset(logic [11:0] m);
        flag_set = m; step(1); flag_set = '0;
    endtask

    task automatic fclr(logic [11:0] m);
        flag_clr = m; step(1); flag_clr = '0;
    endtask

    task automatic en_wr(logic [11:0] s, logic [11:0] c);
        en_set = s; en_clr = c; step(1); en_set = '0; en_clr = '0;
    endtask

    task automatic ack;
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    endtask

    task automatic reti;
        irq_reti = 1'b1; step(1); irq_reti = 1'b0;
    endtask

    task automatic hw_pulse(int which);
        case (which)
            0: tmr0_ovf = 1'b1;
            1: tmr1_ovf = 1'b1;
            2: ser_rx_done = 1'b1;
            3: ser_tx_done = 1'b1;
            4: tmr2_ovf = 1'b1;
            default: tmr2_ext = 1'b1;
        endcase
        step(1);
        {tmr0_ovf, tmr1_ovf, ser_rx_done, ser_tx_done, tmr2_ovf, tmr2_ext} = '0;
    endtask

    function automatic logic [11:0] rep(int v);
        case (v)
            0: return 12'h001;
            1: return 12'h002;
            2: return 12'h004;
            3: return 12'h008;
            4: return 12'h010;
            5: return 12'h040;
            default: return 12'h100;
        endcase
    endfunction

    function automatic logic [11:0] hw_bit(int which);
        case (which)
            0: return 12'h002;
            1: return 12'h008;
            2: return 12'h010;
            3: return 12'h020;
            4: return 12'h040;
            default: return 12'h080;
        endcase
    endfunction

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        chk("R1 flags", 32'(flags), 0);
        chk("R1 req", 32'(irq_req), 0);
        fset(12'h002); step(1);
        chk("R1 enables zero: no request", 32'(irq_req), 0);
        fclr(12'hFFF);

        // R4: software set/clear of each bit, and hardware pulses
        for (int k = 0; k < 12; k++) begin
            fset(12'(1) << k);
            chk("R4 sw set", 32'(flags), 32'(12'(1) << k));
            fclr(12'(1) << k);
            chk("R4 sw clear", 32'(flags), 0);
        end
        flag_set = 12'h00F; flag_clr = 12'h00F; step(1);
        flag_set = '0; flag_clr = '0;
        chk("R4 set wins", 32'(flags), 32'h00F);
        fclr(12'hFFF);
        for (int w = 0; w < 6; w++) begin
            hw_pulse(w);
            chk("R4 hw pulse", 32'(flags), 32'(hw_bit(w)));
            fclr(12'hFFF);
        end
        for (int e = 0; e < 4; e++) begin
            i2c_evt = 4'(1) << e; step(1); i2c_evt = '0;
            chk("R4 i2c pulse", 32'(flags), 32'(12'h100 << e));
            fclr(12'hFFF);
        end

        // R5: per-source and global masking
        en_wr(12'h800, 12'h000);
        fset(12'h002); step(1);
        chk("R5 vector enable off", 32'(irq_req), 0);
        en_wr(12'h002, 12'h800); step(1);
        chk("R5 global off", 32'(irq_req), 0);
        en_wr(12'h800, 12'h000); step(1);
        chk("R5 enabled request", 32'(irq_req), 1);
        chk("R5 vector", 32'(irq_vec), 1);
        ack();
        chk("R8 timer0 autoclear", 32'(flags), 0);
        reti();

        // R11: OR of shared flags, I2C per-event gating
        en_wr(12'h000, 12'hFFF);
        en_wr(12'hA00 | 12'h040 | 12'h030, 12'h000); // global, i2c evt2, vec6, vec4, vec5
        fset(12'h100); step(1);
        chk("R11 i2c event disabled", 32'(irq_req), 0);
        fset(12'h400); step(1);
        chk("R11 i2c enabled event req", 32'(irq_req), 1);
        chk("R11 i2c vector", 32'(irq_vec), 6);
        ack();
        chk("R9 i2c flags kept", 32'(flags), 32'h500);
        fclr(12'hFFF); reti();
        hw_pulse(3); step(1);
        chk("R11 serial tx alone", 32'(irq_vec), 4);
        chk("R11 serial req", 32'(irq_req), 1);
        ack();
        chk("R9 serial tx kept", 32'(flags), 32'h020);
        fclr(12'hFFF); reti();
        hw_pulse(5); step(1);
        chk("R11 timer2 transition alone", 32'(irq_vec), 5);
        ack();
        chk("R9 timer2 kept", 32'(flags), 32'h080);
        fclr(12'hFFF); reti();
        chk("R10 idle after reti", 32'(irq_req), 0);

        // R3: level mode on pin 0
        en_wr(12'h801, 12'h7FE);
        ext_mode = 2'b00;
        ext_pin[0] = 1'b0; step(PIN_WAIT);
        chk("R3 level flag", 32'(flags[0]), 1);
        chk("R3 level req vec", 32'(irq_vec), 0);
        ext_pin[0] = 1'b1; step(PIN_WAIT);
        chk("R3 flag held after high", 32'(flags[0]), 1);
        ack();
        chk("R9 level flag kept", 32'(flags[0]), 1);
        fclr(12'hFFF); reti();
        chk("R3 idle", 32'(irq_req), 0);

        // R2: edge mode on pin 1
        ext_mode = 2'b11;
        en_wr(12'h804, 12'h000);
        step(PIN_WAIT);
        chk("R2 no event while high", 32'(flags[2]), 0);
        ext_pin[1] = 1'b0; step(PIN_WAIT);
        chk("R2 edge flag", 32'(flags[2]), 1);
        chk("R2 edge vec", 32'(irq_vec), 2);
        ack();
        chk("R8 edge autoclear", 32'(flags[2]), 0);
        reti();
        step(3 * DIV);
        chk("R2 steady low no retrigger", 32'(flags[2]), 0);
        chk("R2 steady low no req", 32'(irq_req), 0);
        ext_pin[1] = 1'b1; step(PIN_WAIT);

        // R7 and R10: held vector, in-service blocking, follow-up request
        en_wr(12'hFFF, 12'h000);
        fset(12'h008); step(1);
        chk("R7 vec timer1", 32'(irq_vec), 3);
        fset(12'h001); step(1);
        chk("R7 vec held", 32'(irq_vec), 3);
        chk("R7 req held", 32'(irq_req), 1);
        ack();
        chk("R8 timer1 autoclear", 32'(flags), 32'h001);
        step(2);
        chk("R10 blocked in service", 32'(irq_req), 0);
        reti();
        chk("R10 idle right after reti", 32'(irq_req), 0);
        step(1);
        chk("R10 next request", 32'(irq_req), 1);
        chk("R10 next vector", 32'(irq_vec), 0);
        ack();
        chk("R8 pin0 edge autoclear", 32'(flags), 0);
        reti();

        // R6, R8, R9, R10: all ordered pairs of vectors
        for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 7; b++) begin
                int win;
                logic [11:0] left;
                win  = (a < b) ? a : b;
                left = rep(a) | rep(b);
                if (win <= 3) left = left & ~rep(win);
                fset(rep(a) | rep(b)); step(1);
                chk("R6 pair req", 32'(irq_req), 1);
                chk("R6 pair winner", 32'(irq_vec), 32'(win));
                ack();
                chk("R8 R9 flags after ack", 32'(flags), 32'(left));
                step(1);
                chk("R10 pair in service", 32'(irq_req), 0);
                fclr(12'hFFF); reti();
            end
        end

        done = 1;
        finish_run();
    end
endmodule